// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block watches the external bus so that a cycle left unanswered by a missing or slow device cannot stall the processor. When a cycle starts, it counts bus clocks. If the normal ready never comes back within a fixed number of clocks, the block ends the cycle by pulling its own active-low ready for a single clock. That pulse is merged with the system ready that goes to the processor. At the same moment it sets a sticky timeout flag, which can drive a status indicator.

Software controls the block through two command bits. The first is an active-low enable: 0 means the watchdog runs, and this is the state after reset. The second is a clear pulse that drops the flag. At bus clocks of up to 33 MHz, the default limit of 512 clocks ends a hung cycle after about 15.5 us.

Top module: `bus_timeout_monitor`

## Requirements
- R1: After reset, `force_rdy_n` is 1, `tout_flag` is 0 and `rdy_n_out` follows `rdy_n_in`.
- R2: With `wd_disable` = 0, call the edge that samples `cyc_start` high E0. If `rdy_n_in` is high at edges E1 through E`LIMIT`, then `force_rdy_n` goes low right after edge E`LIMIT`. It is never low before that edge.
- R3: A forced ready lasts exactly one bus clock.
- R4: `rdy_n_out` is the AND of `rdy_n_in` and `force_rdy_n`, so either source pulling low makes the combined ready low.
- R5: If `rdy_n_in` is sampled low at any edge E1 through E`LIMIT`, including E`LIMIT` itself, the cycle ends without a timeout.
- R6: A `cyc_start` seen while a cycle is still open restarts the count from that edge.
- R7: `tout_flag` rises at the same edge at which the forced ready begins. It stays set through later cycles that complete normally.
- R8: A `flag_clear` pulse sampled high clears `tout_flag` at that edge. If a timeout fires at the same edge, the flag stays set.
- R9: While `wd_disable` = 1, the count is held at zero, no cycle is tracked and `force_rdy_n` stays 1. A start seen while disabled is dropped, so a cycle is only tracked after a later start. `tout_flag` is not changed by disabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_start | input | 1 | Bus cycle start strobe, one clock high |
| rdy_n_in | input | 1 | Normal ready from the rest of the system, active low |
| wd_disable | input | 1 | Active-low enable bit (0 = watchdog in use) |
| flag_clear | input | 1 | Software clear pulse for the timeout flag |
| force_rdy_n | output | 1 | Ready injected by this block, active low |
| rdy_n_out | output | 1 | Combined ready to the processor, active low |
| tout_flag | output | 1 | Sticky timeout flag, drives the status indicator |

## Verification
The bench builds the block with `LIMIT` = 8 instead of 512. This keeps every window short enough to step through edge by edge. The first clock of the forced ready, the clock before it, normal ready arriving on the very last allowed edge, and a restart two clocks before expiry can then all be checked at exact cycle positions. The short limit also makes room for longer disabled stretches of twice the limit, for a clear that collides with a firing timeout, and for the flag staying set across later normal cycles.

// File: rtl/bto_pkg.sv
package bto_pkg;
    // Whether a bus cycle is currently being timed
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_OPEN = 1'b1
    } phase_e;

    typedef struct packed {
        logic flag;
    } flag_st_t;
endpackage

// File: rtl/bto_counter.sv
module bto_counter
    import bto_pkg::*;
#(
    parameter int LIMIT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic start,
    input  logic rdy_n,
    output logic fire,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             expire;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.expire = 1'b0;
        if (!run) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
        end else if (start) begin
            st_d.phase = PH_OPEN;
            st_d.cnt   = ONE;
        end else if (st_q.phase == PH_OPEN) begin
            if (!rdy_n) begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end else if (st_q.cnt == LAST) begin
                st_d.phase  = PH_IDLE;
                st_d.cnt    = '0;
                st_d.expire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, expire: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fire   = st_d.expire;
    assign expire = st_q.expire;
endmodule

// File: rtl/bto_flag.sv
module bto_flag
    import bto_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set) begin
            st_d.flag = 1'b1;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor #(
    parameter int LIMIT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic rdy_n_in,
    input  logic wd_disable,
    input  logic flag_clear,
    output logic force_rdy_n,
    output logic rdy_n_out,
    output logic tout_flag
);
    logic fire;
    logic expire;

    bto_counter #(.LIMIT(LIMIT)) cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (~wd_disable),
        .start  (cyc_start),
        .rdy_n  (rdy_n_in),
        .fire   (fire),
        .expire (expire)
    );

    bto_flag flag_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fire),
        .clr   (flag_clear),
        .flag  (tout_flag)
    );

    assign force_rdy_n = ~(expire & ~wd_disable);
    assign rdy_n_out   = rdy_n_in & force_rdy_n;
endmodule

// File: rtl/bus_timeout_monitor_chk.sv
module bus_timeout_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_start,
    input logic rdy_n_in,
    input logic wd_disable,
    input logic flag_clear,
    input logic force_rdy_n,
    input logic rdy_n_out,
    input logic tout_flag
);
    a_r3_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !force_rdy_n |=> force_rdy_n);

    a_r4_merge: assert property (@(posedge clk) disable iff (!rst_n)
        !force_rdy_n |-> !rdy_n_out);

    a_r7_flag_with_force: assert property (@(posedge clk) disable iff (!rst_n)
        !force_rdy_n |-> tout_flag);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_flag && !flag_clear) |=> tout_flag);

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clear |=> (!tout_flag || !force_rdy_n));

    a_r5_no_force_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n_in && !cyc_start) |=> force_rdy_n);

    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        wd_disable |=> (force_rdy_n || !wd_disable));
endmodule

bind bus_timeout_monitor bus_timeout_monitor_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start   (cyc_start),
    .rdy_n_in    (rdy_n_in),
    .wd_disable  (wd_disable),
    .flag_clear  (flag_clear),
    .force_rdy_n (force_rdy_n),
    .rdy_n_out   (rdy_n_out),
    .tout_flag   (tout_flag)
);

// File: tb/bus_timeout_monitor_tb_top.sv
module bus_timeout_monitor_tb_top;
    localparam int LIM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 1'b0;
    logic rdy_n_in = 1'b1;
    logic wd_disable = 1'b0;
    logic flag_clear = 1'b0;
    logic force_rdy_n, rdy_n_out, tout_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bus_timeout_monitor #(.LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .rdy_n_in(rdy_n_in),
        .wd_disable(wd_disable), .flag_clear(flag_clear),
        .force_rdy_n(force_rdy_n), .rdy_n_out(rdy_n_out), .tout_flag(tout_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Open a cycle: afterwards the sampling edge E0 has passed
    task automatic open_cycle();
        cyc_start = 1'b1;
        tick();
        cyc_start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 force", int'(force_rdy_n), 1);
        chk("R1 flag", int'(tout_flag), 0);
        rdy_n_in = 1'b0; #1;
        chk("R1 R4 merge low", int'(rdy_n_out), 0);
        rdy_n_in = 1'b1; #1;
        chk("R1 R4 merge high", int'(rdy_n_out), 1);
    endtask

    task automatic t_timeout();
        open_cycle();
        for (int k = 1; k < LIM; k++) begin
            tick();
            chk("R2 no early force", int'(force_rdy_n), 1);
        end
        tick();
        chk("R2 force at limit", int'(force_rdy_n), 0);
        chk("R4 merged during force", int'(rdy_n_out), 0);
        chk("R7 flag with force", int'(tout_flag), 1);
        tick();
        chk("R3 single clock", int'(force_rdy_n), 1);
    endtask

    task automatic t_sticky_normal();
        open_cycle();
        repeat (3) tick();
        rdy_n_in = 1'b0;
        tick();
        rdy_n_in = 1'b1;
        for (int k = 0; k < LIM + 3; k++) begin
            tick();
            chk("R5 normal end no force", int'(force_rdy_n), 1);
        end
        chk("R7 flag sticky", int'(tout_flag), 1);
    endtask

    task automatic t_clear();
        flag_clear = 1'b1;
        tick();
        flag_clear = 1'b0;
        chk("R8 clear", int'(tout_flag), 0);
    endtask

    task automatic t_last_edge_ready();
        open_cycle();
        repeat (LIM - 1) tick();
        rdy_n_in = 1'b0;
        tick();
        chk("R5 ready at last edge", int'(force_rdy_n), 1);
        rdy_n_in = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R5 stays quiet", int'(force_rdy_n), 1);
        end
        chk("R5 flag untouched", int'(tout_flag), 0);
    endtask

    task automatic t_restart();
        open_cycle();
        repeat (LIM - 2) tick();
        open_cycle();
        for (int k = 1; k < LIM; k++) begin
            tick();
            chk("R6 restarted count", int'(force_rdy_n), 1);
        end
        tick();
        chk("R6 force after restart", int'(force_rdy_n), 0);
        tick();
    endtask

    task automatic t_clear_collide();
        flag_clear = 1'b1;
        tick();
        flag_clear = 1'b0;
        open_cycle();
        repeat (LIM - 1) tick();
        flag_clear = 1'b1;
        tick();
        flag_clear = 1'b0;
        chk("R8 set wins over clear", int'(tout_flag), 1);
        chk("R8 force at collide", int'(force_rdy_n), 0);
        tick();
    endtask

    task automatic t_disable();
        wd_disable = 1'b1;
        tick();
        open_cycle();
        for (int k = 0; k < 2 * LIM; k++) begin
            tick();
            chk("R9 no force while off", int'(force_rdy_n), 1);
        end
        chk("R9 flag kept while off", int'(tout_flag), 1);
        open_cycle();
        wd_disable = 1'b0;
        for (int k = 0; k < 2 * LIM; k++) begin
            tick();
            chk("R9 dropped start", int'(force_rdy_n), 1);
        end
        flag_clear = 1'b1;
        tick();
        flag_clear = 1'b0;
        open_cycle();
        repeat (LIM - 1) tick();
        chk("R9 fresh count", int'(force_rdy_n), 1);
        tick();
        chk("R9 timeout after enable", int'(force_rdy_n), 0);
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_timeout();
        t_sticky_normal();
        t_clear();
        t_last_edge_ready();
        t_restart();
        t_clear_collide();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule